// File: doc/BRIEF.md
# Framed Word-to-Byte Link Transmitter

This block feeds a byte-wide serializer input. On a word clock it takes a 20-bit word and a data-available flag. From them it builds a 24-bit frame: a 4-bit control code sits above the word. When the flag is low it builds an empty frame, whose payload is zero. A byte clock runs at exactly three times the word clock, from the same clock source and phase-aligned with it. On that clock a three-phase gearbox sends each frame as three bytes, most significant byte first. A marker output is high with the first byte, so the serializer side can find frame boundaries.

The top holds several lanes built from the same logic. By default there are two, for example one for event readout and one for region data. Each lane has its own word, flag and active-low asynchronous reset. While a lane is held in reset, its byte output is zero and its marker is low. After release, the lane keeps sending zero bytes until the first frame built after the release reaches the gearbox.

Top module: `fbt_dual_tx`

## Requirements
- R1: A word sampled with the flag high becomes the frame {4'b1010, word}, so frame bits 23:20 hold 1010 and bits 19:0 hold the word.
- R2: A word sampled with the flag low becomes the frame {4'b0101, 20'h00000}. The value on the word input is ignored, so the second and third bytes are zero.
- R3: A frame leaves in three consecutive byte-clock cycles in this order: bits 23:16, bits 15:8, bits 7:0. The marker output is high only while bits 23:16 are on the output.
- R4: The first byte of a frame appears after the first byte-clock edge that follows the word-clock edge that sampled the word. It stays for one byte-clock cycle. This latency is the same for data frames and empty frames.
- R5: While a lane's reset is low, its byte output is zero and its marker is low. After release, the lane's bytes stay zero and its marker stays low until the first frame sampled after the release is sent.
- R6: Once a lane is running, its marker is high for exactly one byte-clock cycle in every three.
- R7: Each lane runs independently. Holding one lane in reset does not disturb the frames of another lane.
- R8: When words arrive on every word-clock cycle, every sampled word is sent exactly once, in order, with no frame dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_word_i | input | 1 | Word clock. Input words are sampled on its rising edge |
| clk_byte_i | input | 1 | Byte clock: three times the word clock, phase-aligned |
| rst_ni | input | LANES | Active-low asynchronous reset, one bit per lane |
| word_i | input | LANES x WORD_W | Input word for each lane |
| dav_i | input | LANES | Data-available flag for each lane |
| byte_o | output | LANES x BYTE_W | Byte sent to the serializer for each lane |
| frame_mark_o | output | LANES | High while the first byte of a frame is on byte_o |

## Verification
Each kind of internal fault shows up at the ports, most within one frame time:
- A phase counter that loses its alignment shows up at once: the marker spacing moves off three byte cycles, or the marker lands on a byte that is not the expected control byte.
- A holding register that is loaded at the wrong moment corrupts the second or third byte of the same frame.
- A word-edge detector that fires late or early shifts the marker away from its fixed position after the sampling edge, within one word cycle.
- A lost reset shows as a non-zero byte in the first byte cycle of reset.

The bench checks every byte against a frame it predicts itself. It also checks the time from the sampling edge to the first byte.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
  localparam int CTRL_W = 4;
  localparam logic [CTRL_W-1:0] CTRL_DATA  = 4'b1010;
  localparam logic [CTRL_W-1:0] CTRL_EMPTY = 4'b0101;
endpackage

// File: rtl/fbt_frame_enc.sv
module fbt_frame_enc #(
  parameter int WORD_W  = 20,
  parameter int FRAME_W = fbt_pkg::CTRL_W + WORD_W
) (
  input  logic               clk_word_i,
  input  logic               rst_ni,
  input  logic [WORD_W-1:0]  word_i,
  input  logic               dav_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               tick_o
);
  import fbt_pkg::*;

  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    if (dav_i) frame_d = {CTRL_DATA, word_i};
    else       frame_d = {CTRL_EMPTY, {WORD_W{1'b0}}};
  end

  // tick_o toggles once per word, the byte side detects the change
  always_ff @(posedge clk_word_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      tick_o  <= 1'b0;
    end else begin
      frame_o <= frame_d;
      tick_o  <= ~tick_o;
    end
  end
endmodule

// File: rtl/fbt_gearbox.sv
module fbt_gearbox #(
  parameter int FRAME_W = 24,
  parameter int BYTE_W  = 8
) (
  input  logic               clk_byte_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_i,
  output logic [BYTE_W-1:0]  byte_o,
  output logic               mark_o
);
  localparam int NBYTES = FRAME_W / BYTE_W;
  localparam int PH_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NBYTES - 1);

  logic               seen_q, run_q, run_d, align;
  logic [PH_W-1:0]    phase_q, phase_d;
  logic [FRAME_W-1:0] hold_q, hold_d;
  logic [BYTE_W-1:0]  byte_q, byte_d;
  logic               mark_q;
  logic [BYTE_W-1:0]  slice [NBYTES];

  // first byte edge after a word edge
  assign align = tick_i ^ seen_q;
  assign run_d = run_q | align;

  always_comb begin
    if (align)                 phase_d = '0;
    else if (phase_q == PH_LAST) phase_d = '0;
    else                       phase_d = phase_q + 1'b1;
    hold_d = align ? frame_i : hold_q;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_slice
    assign slice[g] = hold_d[FRAME_W-1-g*BYTE_W -: BYTE_W];
  end

  assign byte_d = slice[phase_d];

  always_ff @(posedge clk_byte_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      run_q   <= 1'b0;
      phase_q <= PH_LAST;
      hold_q  <= '0;
      byte_q  <= '0;
      mark_q  <= 1'b0;
    end else begin
      seen_q <= tick_i;
      run_q  <= run_d;
      if (run_d) begin
        phase_q <= phase_d;
        hold_q  <= hold_d;
        byte_q  <= byte_d;
        mark_q  <= (phase_d == '0);
      end
    end
  end

  assign byte_o = byte_q;
  assign mark_o = mark_q;
endmodule

// File: rtl/fbt_lane.sv
module fbt_lane #(
  parameter int WORD_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic              clk_word_i,
  input  logic              clk_byte_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              dav_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              mark_o
);
  localparam int FRAME_W = fbt_pkg::CTRL_W + WORD_W;

  logic [FRAME_W-1:0] frame;
  logic               tick;

  fbt_frame_enc #(.WORD_W(WORD_W), .FRAME_W(FRAME_W)) i_enc (
    .clk_word_i (clk_word_i),
    .rst_ni     (rst_ni),
    .word_i     (word_i),
    .dav_i      (dav_i),
    .frame_o    (frame),
    .tick_o     (tick)
  );

  fbt_gearbox #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) i_gbx (
    .clk_byte_i (clk_byte_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame),
    .tick_i     (tick),
    .byte_o     (byte_o),
    .mark_o     (mark_o)
  );
endmodule

// File: rtl/fbt_dual_tx.sv
module fbt_dual_tx #(
  parameter int LANES  = 2,
  parameter int WORD_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                          clk_word_i,
  input  logic                          clk_byte_i,
  input  logic [LANES-1:0]              rst_ni,
  input  logic [LANES-1:0][WORD_W-1:0]  word_i,
  input  logic [LANES-1:0]              dav_i,
  output logic [LANES-1:0][BYTE_W-1:0]  byte_o,
  output logic [LANES-1:0]              frame_mark_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fbt_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_lane (
      .clk_word_i (clk_word_i),
      .clk_byte_i (clk_byte_i),
      .rst_ni     (rst_ni[l]),
      .word_i     (word_i[l]),
      .dav_i      (dav_i[l]),
      .byte_o     (byte_o[l]),
      .mark_o     (frame_mark_o[l])
    );
  end
endmodule

// File: rtl/fbt_dual_tx_chk.sv
module fbt_dual_tx_chk #(
  parameter int LANES  = 2,
  parameter int WORD_W = 20,
  parameter int BYTE_W = 8
) (
  input logic                          clk_word_i,
  input logic                          clk_byte_i,
  input logic [LANES-1:0]              rst_ni,
  input logic [LANES-1:0][WORD_W-1:0]  word_i,
  input logic [LANES-1:0]              dav_i,
  input logic [LANES-1:0][BYTE_W-1:0]  byte_o,
  input logic [LANES-1:0]              frame_mark_o
);
  import fbt_pkg::*;

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    logic [CTRL_W-1:0] ctrl;
    assign ctrl = byte_o[l][BYTE_W-1 -: CTRL_W];

    // R5: quiet outputs while held in reset
    always @(negedge clk_byte_i) begin
      if (!rst_ni[l]) begin
        p_reset_quiet_r5: assert (byte_o[l] == '0 && !frame_mark_o[l]);
      end
    end

    p_mark_cadence_r6: assert property (@(posedge clk_byte_i) disable iff (!rst_ni[l])
      frame_mark_o[l] |=> !frame_mark_o[l] ##1 !frame_mark_o[l] ##1 frame_mark_o[l]);

    p_ctrl_code_r3: assert property (@(posedge clk_byte_i) disable iff (!rst_ni[l])
      frame_mark_o[l] |-> (ctrl == CTRL_DATA || ctrl == CTRL_EMPTY));

    p_empty_head_r2: assert property (@(posedge clk_byte_i) disable iff (!rst_ni[l])
      (frame_mark_o[l] && ctrl == CTRL_EMPTY) |-> byte_o[l][BYTE_W-CTRL_W-1:0] == '0);

    p_empty_tail_r2: assert property (@(posedge clk_byte_i) disable iff (!rst_ni[l])
      (frame_mark_o[l] && ctrl == CTRL_EMPTY) |=> byte_o[l] == '0);
  end
endmodule

bind fbt_dual_tx fbt_dual_tx_chk #(.LANES(LANES), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_chk (
  .clk_word_i   (clk_word_i),
  .clk_byte_i   (clk_byte_i),
  .rst_ni       (rst_ni),
  .word_i       (word_i),
  .dav_i        (dav_i),
  .byte_o       (byte_o),
  .frame_mark_o (frame_mark_o)
);

// File: tb/test_fbt_dual_tx.sv
module test_fbt_dual_tx;
  localparam int LANES = 2;

  logic                  clk_b, clk_w;
  logic [LANES-1:0]      rst_n;
  logic [LANES-1:0][19:0] word;
  logic [LANES-1:0]      dav;
  logic [LANES-1:0][7:0] byte_o;
  logic [LANES-1:0]      mark;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  fbt_dual_tx #(.LANES(LANES), .WORD_W(20), .BYTE_W(8)) i_fbt_dual_tx (
    .clk_word_i   (clk_w),
    .clk_byte_i   (clk_b),
    .rst_ni       (rst_n),
    .word_i       (word),
    .dav_i        (dav),
    .byte_o       (byte_o),
    .frame_mark_o (mark)
  );

  // byte clock period 10, word clock period 30, rising edges aligned
  initial begin
    clk_b = 0; clk_w = 0;
    forever begin
      clk_b = 1; clk_w = 1;
      #5 clk_b = 0;
      #5 clk_b = 1;
      #5 clk_b = 0; clk_w = 0;
      #5 clk_b = 1;
      #5 clk_b = 0;
      #5;
    end
  end

  task automatic chk(input bit ok, input string req, input int lane,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s lane%0d act=%h exp=%h t=%0t", req, lane, act, exp, $time);
    end
  endtask

  for (genvar l = 0; l < LANES; l++) begin : g_mon
    logic [23:0] q[$];
    longint      tq[$];
    logic [23:0] cur = '0;
    int          idx = 4;   // 4: not started, 3: expect marker
    int          pushed = 0;
    int          got = 0;

    always @(posedge clk_w) begin
      if (rst_n[l]) begin
        q.push_back(dav[l] ? {4'b1010, word[l]} : 24'h500000);
        tq.push_back(longint'($time));
        pushed++;
      end
    end

    always @(negedge clk_b) begin
      if (!rst_n[l]) begin
        chk(byte_o[l] == 8'h00 && !mark[l], "R5 reset quiet", l, {23'd0, mark[l], byte_o[l]}, 32'h0);
        q.delete(); tq.delete();
        pushed = got; idx = 4;
      end else if (mark[l]) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4 marker without frame", l, 32'(byte_o[l]), 32'h0);
          cur = '0;
        end else begin
          longint t0;
          cur = q.pop_front();
          t0 = tq.pop_front();
          got++;
          chk(longint'($time) - t0 == 15, "R4 latency", l, 32'(longint'($time) - t0), 32'd15);
          chk(q.size() == 0, "R8 backlog", l, 32'(q.size()), 32'd0);
        end
        if (idx != 3 && idx != 4)
          chk(1'b0, "R6 early marker", l, 32'(idx), 32'd3);
        chk(byte_o[l] == cur[23:16], "R3 first byte", l, 32'(byte_o[l]), 32'(cur[23:16]));
        idx = 1;
      end else if (idx == 4) begin
        chk(byte_o[l] == 8'h00, "R5 zero before first frame", l, 32'(byte_o[l]), 32'h0);
      end else if (idx == 3) begin
        chk(1'b0, "R6 missing marker", l, 32'(byte_o[l]), 32'h0);
      end else begin
        logic [7:0] e;
        string      r;
        e = (idx == 1) ? cur[15:8] : cur[7:0];
        r = (cur[23:20] == 4'b1010) ? "R1 data byte" : "R2 empty byte";
        chk(byte_o[l] == e, r, l, 32'(byte_o[l]), 32'(e));
        idx++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_b);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    int          g0;
    rst_n = '0; word = '0; dav = '0;
    repeat (3) @(negedge clk_w);
    #2 rst_n = '1;

    // R1 walking ones on lane 0, R2 ignored word on lane 1
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_w);
      word[0] = 20'(1 << i);  dav[0] = 1'b1;
      word[1] = ~20'(1 << i); dav[1] = 1'b0;
    end

    // R4/R8 mixed flags, back-to-back words
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_w);
      word[0] = lfsr[19:0];  dav[0] = lfsr[23];
      word[1] = lfsr[31:12]; dav[1] = lfsr[5];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    end

    // R7 lane 1 held in reset while lane 0 keeps sending
    @(negedge clk_w);
    #2 rst_n[1] = 1'b0;
    g0 = g_mon[0].got;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_w);
      word[0] = 20'h5A5A5 ^ 20'(i); dav[0] = 1'b1;
      word[1] = 20'hFFFFF;          dav[1] = 1'b1;
    end
    chk(g_mon[0].got - g0 >= 5, "R7 lane0 during lane1 reset", 0, 32'(g_mon[0].got - g0), 32'd5);
    #2 rst_n[1] = 1'b1;

    // corner words on both lanes
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_w);
      word[0] = i[1] ? 20'h00000 : 20'hFFFFF; dav[0] = i[0];
      word[1] = i[2] ? 20'hFFFFF : 20'h80001; dav[1] = ~i[0];
    end

    // R5 full reset and restart
    @(negedge clk_w);
    #2 rst_n = '0;
    repeat (2) @(negedge clk_w);
    #2 rst_n = '1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_w);
      word[0] = 20'(i * 20'h1111); dav[0] = 1'b1;
      word[1] = 20'(i * 20'h0F0F); dav[1] = i[0];
    end

    @(negedge clk_w);
    #2;
    for (int l = 0; l < LANES; l++) begin
      int sz, gt, ps;
      if (l == 0) begin sz = g_mon[0].q.size(); gt = g_mon[0].got; ps = g_mon[0].pushed; end
      else        begin sz = g_mon[1].q.size(); gt = g_mon[1].got; ps = g_mon[1].pushed; end
      chk(sz == 0, "R8 queue drained", l, 32'(sz), 32'd0);
      chk(gt == ps, "R8 frames sent once", l, 32'(gt), 32'(ps));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule